// File: doc/BRIEF.md
# Mode-Selected Bit-Slice ALU

This block is a purely combinational arithmetic and logic unit. It is a row of identical one-bit slices joined by a rippling carry. A single mode input chooses between a bitwise logic mode and an arithmetic mode.

In logic mode every slice works on its own bit and ignores the carry. In arithmetic mode the slices form a ripple adder. Its first operand is either A or the complement of A, and its second operand is either B or zero. A carry input adds one to the sum.

The same two select bits do the operand steering in both modes. Select bit 0 decides whether A is inverted, and select bit 1 decides whether B reaches the slice. Between them they give twelve distinct functions across the mode and carry-input settings. The data width is a parameter.

Top module: `bitslice_alu`

## Requirements
- R1: With `mode_arith`=0 (logic mode) the result is computed bit by bit from `sel` (`sel[1]` is S1, `sel[0]` is S0): `sel`=00 gives A, 01 gives NOT A, 10 gives A XOR B, and 11 gives A XNOR B.
- R2: In logic mode `carry_out` is 0 for every operand and `carry_in` value.
- R3: In logic mode neither `result` nor `carry_out` depends on `carry_in`.
- R4: With `mode_arith`=1 and `sel[1]`=0, B is blocked from the slices. `sel`=00 gives A plus `carry_in`, and `sel`=01 gives (NOT A) plus `carry_in`, both modulo 2^DATA_W.
- R5: With `mode_arith`=1 and `sel`=10, `result` is A plus B plus `carry_in`, modulo 2^DATA_W.
- R6: With `mode_arith`=1 and `sel`=11, `result` is (NOT A) plus B plus `carry_in`. When `carry_in`=1 this equals B minus A, modulo 2^DATA_W.
- R7: In arithmetic mode `carry_out` is bit DATA_W of the full (DATA_W+1)-bit sum of the steered A, the steered B and `carry_in`. For example, A all ones with `sel`=00 and `carry_in`=1 gives `carry_out`=1 and `result`=0.
- R8: The behaviour of R1 to R7 holds at any value of DATA_W, with each slice's carry feeding the next more significant slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_arith | input | 1 | 0 selects logic mode, 1 selects arithmetic mode |
| sel | input | 2 | Function select: bit 0 inverts A, bit 1 admits B |
| carry_in | input | 1 | Carry into the least significant slice; used only in arithmetic mode |
| op_a | input | DATA_W | First operand A |
| op_b | input | DATA_W | Second operand B |
| result | output | DATA_W | Function result F |
| carry_out | output | 1 | Carry out of the most significant slice; 0 in logic mode |

## Verification
The bench builds one instance at the default DATA_W of 4. At that width it can sweep every operand pair under all 16 combinations of mode, select and carry input. This covers every carry pattern through the ripple chain, including the all-ones and zero corners. A second instance at DATA_W of 8 runs a strided grid of operands under the same sixteen controls. This shows that the slice chain and the carry out of the top slice scale with the parameter and do not depend on the 4-bit corner.

// File: rtl/alu_pkg.sv
package alu_pkg;

  // Function select codes; bit 0 inverts A, bit 1 admits B
  localparam logic [1:0] SEL_PASS_A = 2'b00;
  localparam logic [1:0] SEL_INV_A  = 2'b01;
  localparam logic [1:0] SEL_MIX    = 2'b10;
  localparam logic [1:0] SEL_MIX_N  = 2'b11;

  localparam int SEL_INV_BIT   = 0;
  localparam int SEL_ADMIT_BIT = 1;

  typedef struct packed {
    logic a_eff;
    logic b_eff;
  } slice_opnd_t;

endpackage

// File: rtl/alu_operand_steer.sv
module alu_operand_steer
  import alu_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output slice_opnd_t       opnd [DATA_W]
);

  logic inv_a;
  logic admit_b;

  assign inv_a   = sel[SEL_INV_BIT];
  assign admit_b = sel[SEL_ADMIT_BIT];

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    always_comb begin
      opnd[i].a_eff = op_a[i] ^ inv_a;
      opnd[i].b_eff = op_b[i] & admit_b;
    end
  end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic        arith,
  input  slice_opnd_t opnd,
  input  logic        c_in,
  output logic        f,
  output logic        c_out
);

  logic c_use;
  logic a_x_c;

  always_comb begin
    c_use = arith & c_in;
    a_x_c = opnd.a_eff ^ c_use;
    f     = a_x_c ^ opnd.b_eff;
    c_out = arith & ((opnd.a_eff & c_use) | (opnd.b_eff & a_x_c));
  end

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              mode_arith,
  input  logic [1:0]        sel,
  input  logic              carry_in,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);

  localparam int CHAIN_LEN = DATA_W + 1;

  slice_opnd_t          opnd [DATA_W];
  logic [CHAIN_LEN-1:0] chain;

  alu_operand_steer #(.DATA_W(DATA_W)) u_steer (
    .sel  (sel),
    .op_a (op_a),
    .op_b (op_b),
    .opnd (opnd)
  );

  assign chain[0] = carry_in;

  for (genvar i = 0; i < DATA_W; i++) begin : g_slice
    alu_bit_slice u_slice (
      .arith (mode_arith),
      .opnd  (opnd[i]),
      .c_in  (chain[i]),
      .f     (result[i]),
      .c_out (chain[i+1])
    );
  end

  assign carry_out = chain[DATA_W];

endmodule

// File: rtl/bitslice_alu_checker.sv
module bitslice_alu_checker #(
  parameter int DATA_W = 4
) (
  input logic              mode_arith,
  input logic [1:0]        sel,
  input logic              carry_in,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [DATA_W-1:0] result,
  input logic              carry_out
);

  logic [DATA_W:0] add_ab;
  logic [DATA_W:0] add_na;

  always_comb begin
    add_ab = {1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, carry_in};
    add_na = {1'b0, ~op_a} + {{DATA_W{1'b0}}, carry_in};
  end

  always_comb begin
    if (!mode_arith) begin
      p_logic_carry_zero_r2: assert (carry_out == 1'b0)
        else $error("carry_out set in logic mode");
      if (sel == 2'b01) begin
        p_logic_invert_r1: assert (result == ~op_a)
          else $error("logic invert mismatch");
      end
      if (sel[1]) begin
        p_logic_xor_r1: assert ((result ^ op_a ^ op_b) == {DATA_W{sel[0]}})
          else $error("logic xor/xnor mismatch");
      end
    end else begin
      if (sel == 2'b10) begin
        p_add_sum_r5: assert ({carry_out, result} == add_ab)
          else $error("add mismatch");
      end
      if (sel == 2'b01) begin
        p_inv_incr_r4: assert ({carry_out, result} == add_na)
          else $error("inverted increment mismatch");
      end
      if (sel == 2'b11 && carry_in) begin
        p_sub_diff_r6: assert (result == DATA_W'(op_b - op_a))
          else $error("subtract mismatch");
      end
    end
  end

endmodule

bind bitslice_alu bitslice_alu_checker #(.DATA_W(DATA_W)) u_checker (
  .mode_arith (mode_arith),
  .sel        (sel),
  .carry_in   (carry_in),
  .op_a       (op_a),
  .op_b       (op_b),
  .result     (result),
  .carry_out  (carry_out)
);

// File: tb/tb_bitslice_alu.sv
`timescale 1ns/1ps
module tb_bitslice_alu;

  localparam int W  = 4;
  localparam int WW = 8;

  logic clk;
  logic rst_n;

  logic          m;
  logic [1:0]    s;
  logic          ci;
  logic [W-1:0]  a, b, f;
  logic          co;

  logic          wm;
  logic [1:0]    ws;
  logic          wci;
  logic [WW-1:0] wa, wb, wf;
  logic          wco;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  bitslice_alu #(.DATA_W(W)) dut (
    .mode_arith(m), .sel(s), .carry_in(ci),
    .op_a(a), .op_b(b), .result(f), .carry_out(co)
  );

  bitslice_alu #(.DATA_W(WW)) dut_wide (
    .mode_arith(wm), .sel(ws), .carry_in(wci),
    .op_a(wa), .op_b(wb), .result(wf), .carry_out(wco)
  );

  // Reference model written from the requirements
  function automatic logic [WW:0] model(input int width, input logic md,
                                        input logic [1:0] sl, input logic c,
                                        input logic [WW-1:0] x, input logic [WW-1:0] y);
    logic [WW:0] mask, ax, by, r;
    mask = (({{WW{1'b0}}, 1'b1}) << width) - 1'b1;
    ax = sl[0] ? (~{1'b0, x}) & mask : {1'b0, x};
    by = sl[1] ? {1'b0, y} : '0;
    if (!md) begin
      case (sl)
        2'b00: r = {1'b0, x};
        2'b01: r = (~{1'b0, x}) & mask;
        2'b10: r = {1'b0, x ^ y};
        default: r = (~{1'b0, x ^ y}) & mask;
      endcase
    end else begin
      r = ax + by + {{WW{1'b0}}, c};
      r = r & ((mask << 1) | 1'b1);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [WW:0] act, input logic [WW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic md, input logic [1:0] sl, input logic c,
                       input logic [W-1:0] x, input logic [W-1:0] y);
    @(posedge clk); #1;
    m = md; s = sl; ci = c; a = x; b = y;
    @(negedge clk);
  endtask

  function automatic logic [WW:0] got();
    return {{(WW-W){1'b0}}, co, f};
  endfunction

  task automatic t_reset_state();
    drive(1'b0, 2'b00, 1'b0, '0, '0);
    check("R1 reset-state zero", got(), '0);
  endtask

  // R1, R2, R3: every logic-mode combination, both carry_in values
  task automatic t_logic_mode();
    for (int sl = 0; sl < 4; sl++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++) begin
          logic [WW:0] r0;
          drive(1'b0, sl[1:0], 1'b0, x[3:0], y[3:0]);
          r0 = got();
          check("R1 logic function", r0, model(W, 1'b0, sl[1:0], 1'b0, WW'(x), WW'(y)));
          drive(1'b0, sl[1:0], 1'b1, x[3:0], y[3:0]);
          check("R2 logic carry_out zero", {{WW{1'b0}}, co}, '0);
          check("R3 carry_in ignored", got(), r0);
        end
  endtask

  // R4: B blocked, A or NOT A plus carry_in
  task automatic t_arith_unary();
    for (int sl = 0; sl < 2; sl++)
      for (int c = 0; c < 2; c++)
        for (int x = 0; x < 16; x++)
          for (int y = 0; y < 16; y++) begin
            drive(1'b1, sl[1:0], c[0], x[3:0], y[3:0]);
            check("R4 unary arith", got(), model(W, 1'b1, sl[1:0], c[0], WW'(x), WW'(y)));
          end
    drive(1'b1, 2'b00, 1'b1, 4'hF, 4'h5);
    check("R7 increment wrap carry", got(), {{(WW-W){1'b0}}, 5'b1_0000});
  endtask

  // R5, R7: addition
  task automatic t_arith_add();
    for (int c = 0; c < 2; c++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++) begin
          drive(1'b1, 2'b10, c[0], x[3:0], y[3:0]);
          check("R5 add", got(), model(W, 1'b1, 2'b10, c[0], WW'(x), WW'(y)));
          check("R7 add carry_out", {{WW{1'b0}}, co}, WW'((x + y + c) >> W));
        end
  endtask

  // R6, R7: complement-add and B minus A
  task automatic t_arith_sub();
    for (int c = 0; c < 2; c++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++) begin
          drive(1'b1, 2'b11, c[0], x[3:0], y[3:0]);
          check("R6 complement add", got(), model(W, 1'b1, 2'b11, c[0], WW'(x), WW'(y)));
          if (c == 1)
            check("R6 B minus A", {{(WW-W+1){1'b0}}, f}, WW'((y - x) & 15));
          check("R7 sub carry_out", {{WW{1'b0}}, co}, WW'(((15 - x) + y + c) >> W));
        end
  endtask

  // R8: wider instance on a strided operand grid
  task automatic t_wide();
    for (int md = 0; md < 2; md++)
      for (int sl = 0; sl < 4; sl++)
        for (int c = 0; c < 2; c++)
          for (int x = 0; x < 256; x += 17)
            for (int y = 0; y < 256; y += 51) begin
              @(posedge clk); #1;
              wm = md[0]; ws = sl[1:0]; wci = c[0]; wa = x[7:0]; wb = y[7:0];
              @(negedge clk);
              check("R8 wide instance", {wco, wf},
                    model(WW, md[0], sl[1:0], c[0], WW'(x), WW'(y)));
            end
  endtask

  initial begin
    #(100000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    m = 0; s = 0; ci = 0; a = 0; b = 0;
    wm = 0; ws = 0; wci = 0; wa = 0; wb = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_state();
    t_logic_mode();
    t_arith_unary();
    t_arith_add();
    t_arith_sub();
    t_wide();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule